// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This block sits beside the execute stage of an in-order core and decides, for each 32-bit instruction, whether it takes effect. It keeps the four status flags (negative, zero, carry, overflow). It compares the 4-bit condition field at the top of the instruction word against the current flags. When the condition fails, the execute enable is driven low. The instruction still uses its pipeline slot but writes neither a register nor the flags. No branch is taken and no flush occurs.

A flag-setting instruction, such as a compare, presents its new flag value together with a write request. The flags are loaded at the end of that instruction's cycle, and only if the instruction itself passed its condition. The very next instruction is therefore judged against the updated flags. The condition check is combinational on the instruction word and the flag register, so a decision costs no extra cycle.

Top module: `cond_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, flags_o reads 0000 until the first flag write. exec_en_o is 0 while valid_i is 0.
- R2: The condition code is instr_i[31:28]. Code 1110 (always) enables execution for any flag value.
- R3: Code 1111 never enables execution, whatever the flags.
- R4: The single-flag codes behave as follows. 0000 passes when Z=1 and 0001 when Z=0. 0010 passes when C=1 and 0011 when C=0. 0100 passes when N=1 and 0101 when N=0. 0110 passes when V=1 and 0111 when V=0.
- R5: Code 1000 (unsigned higher) passes when C=1 and Z=0. Code 1001 (unsigned lower or same) passes when C=0 or Z=1.
- R6: Code 1010 (signed greater or equal) passes when N==V. Code 1011 (signed less) passes when N!=V.
- R7: Code 1100 (signed greater) passes when Z=0 and N==V. Code 1101 (signed less or equal) passes when Z=1 or N!=V.
- R8: exec_en_o is 0 whenever valid_i is 0, whatever the condition code.
- R9: A valid, passing instruction with flag_we_i=1 loads flag_val_i into the flags at the next rising clock edge. The flags are packed as {N,Z,C,V} with N in bit 3.
- R10: Flags written by one instruction decide the condition of the instruction presented in the very next cycle.
- R11: A valid instruction whose condition fails leaves the flags unchanged, even when flag_we_i=1.
- R12: The flags stay unchanged when flag_we_i=0, and also when valid_i=0 even if flag_we_i=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word, condition in bits [31:28] |
| flag_we_i | input | 1 | Instruction requests a flag update |
| flag_val_i | input | 4 | New flags {N,Z,C,V} |
| exec_en_o | output | 1 | Instruction takes effect |
| flags_o | output | 4 | Current flags {N,Z,C,V} |

## Verification
Two functions fall into the same cycle: the condition check of an instruction and that same instruction's request to write the flags. The write must be gated by the outcome of the check, which is made against the old flags. The bench provokes this by presenting failing instructions, including the never code, that carry a flag write with a distinct value. It then reads flags_o in the following cycle and expects the old value. Back-to-back pairs, in which a flag-writing instruction is immediately followed by a dependent condition, show that the newly written flags decide the next instruction.

// File: rtl/cond_pkg.sv
package cond_pkg;
  typedef enum logic [3:0] {
    C_EQ = 4'h0, C_NE = 4'h1, C_CS = 4'h2, C_CC = 4'h3,
    C_MI = 4'h4, C_PL = 4'h5, C_VS = 4'h6, C_VC = 4'h7,
    C_HI = 4'h8, C_LS = 4'h9, C_GE = 4'hA, C_LT = 4'hB,
    C_GT = 4'hC, C_LE = 4'hD, C_AL = 4'hE, C_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  logic sgn_ge;
  assign sgn_ge = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i)
      C_EQ: pass_o = flags_i.z;
      C_NE: pass_o = !flags_i.z;
      C_CS: pass_o = flags_i.c;
      C_CC: pass_o = !flags_i.c;
      C_MI: pass_o = flags_i.n;
      C_PL: pass_o = !flags_i.n;
      C_VS: pass_o = flags_i.v;
      C_VC: pass_o = !flags_i.v;
      C_HI: pass_o = flags_i.c && !flags_i.z;
      C_LS: pass_o = !flags_i.c || flags_i.z;
      C_GE: pass_o = sgn_ge;
      C_LT: pass_o = !sgn_ge;
      C_GT: pass_o = !flags_i.z && sgn_ge;
      C_LE: pass_o = flags_i.z || !sgn_ge;
      C_AL: pass_o = 1'b1;
      default: pass_o = 1'b0; // never
    endcase
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import cond_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/cond_unit.sv
module cond_unit
  import cond_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int COND_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               flag_we_i,
  input  logic [COND_W-1:0]  flag_val_i,
  output logic               exec_en_o,
  output logic [COND_W-1:0]  flags_o
);
  localparam int CondLsb = INSTR_W - COND_W;

  cond_e  cond;
  flags_t flags_q;
  logic   pass;
  logic   upd;

  assign cond = cond_e'(instr_i[INSTR_W-1:CondLsb]);

  cond_eval u_eval (
    .cond_i (cond),
    .flags_i(flags_q),
    .pass_o (pass)
  );

  // write gated by own outcome, judged on old flags
  assign exec_en_o = valid_i && pass;
  assign upd       = exec_en_o && flag_we_i;

  flag_reg u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (upd),
    .d_i   (flags_t'(flag_val_i)),
    .q_o   (flags_q)
  );

  assign flags_o = flags_q;

  a_r2_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[INSTR_W-1:CondLsb] == 4'hE) |-> exec_en_o);
  a_r3_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[INSTR_W-1:CondLsb] == 4'hF) |-> !exec_en_o);
  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !exec_en_o);
  a_r7_gt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en_o && instr_i[INSTR_W-1:CondLsb] == 4'hC) |-> (!flags_o[2] && flags_o[3] == flags_o[0]));
  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en_o && flag_we_i) |=> (flags_o == $past(flag_val_i)));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !exec_en_o) |=> $stable(flags_o));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i || !valid_i) |=> $stable(flags_o));
endmodule

// File: tb/cond_unit_bench.sv
`timescale 1ns/1ps
module cond_unit_bench;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        valid_i = 0;
  logic [31:0] instr_i = '0;
  logic        flag_we_i = 0;
  logic [3:0]  flag_val_i = '0;
  logic        exec_en_o;
  logic [3:0]  flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  cond_unit u_cond_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .flag_we_i(flag_we_i), .flag_val_i(flag_val_i),
    .exec_en_o(exec_en_o), .flags_o(flags_o)
  );

  // {flags NZCV, cond, expected exec}
  localparam int NV = 25;
  localparam logic [8:0] VEC [NV] = '{
    {4'b0100, 4'h0, 1'b1}, {4'b0000, 4'h0, 1'b0}, {4'b0000, 4'h1, 1'b1},
    {4'b0100, 4'h1, 1'b0}, {4'b0010, 4'h2, 1'b1}, {4'b0000, 4'h3, 1'b1},
    {4'b1000, 4'h4, 1'b1}, {4'b1000, 4'h5, 1'b0}, {4'b0001, 4'h6, 1'b1},
    {4'b0001, 4'h7, 1'b0}, {4'b0010, 4'h8, 1'b1}, {4'b0110, 4'h8, 1'b0},
    {4'b0110, 4'h9, 1'b1}, {4'b1001, 4'hA, 1'b1}, {4'b1000, 4'hA, 1'b0},
    {4'b1000, 4'hB, 1'b1}, {4'b0000, 4'hC, 1'b1}, {4'b0100, 4'hC, 1'b0},
    {4'b1001, 4'hC, 1'b1}, {4'b0001, 4'hC, 1'b0}, {4'b0100, 4'hD, 1'b1},
    {4'b1000, 4'hD, 1'b1}, {4'b1001, 4'hD, 1'b0}, {4'b1111, 4'hE, 1'b1},
    {4'b0000, 4'hF, 1'b0}
  };

  function automatic string req_of(logic [3:0] c);
    if (c <= 4'h7) return "R4";
    if (c <= 4'h9) return "R5";
    if (c <= 4'hB) return "R6";
    if (c <= 4'hD) return "R7";
    if (c == 4'hE) return "R2";
    return "R3";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one instruction in one cycle; sample before the edge
  task automatic issue(logic v, logic [3:0] c, logic we, logic [3:0] fv);
    @(negedge clk_i);
    valid_i = v; instr_i = {c, 28'h0001234}; flag_we_i = we; flag_val_i = fv;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 0; flag_we_i = 0; instr_i = '0;
    #1;
  endtask

  initial begin
    #1;
    check("R1", flags_o, 4'h0);
    check("R1", exec_en_o, 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    #1;
    check("R1", flags_o, 4'h0);

    for (int i = 0; i < NV; i++) begin
      issue(1, 4'hE, 1, VEC[i][8:5]);
      issue(1, VEC[i][4:1], 0, 4'h0);
      check("R9", flags_o, VEC[i][8:5]);
      check(req_of(VEC[i][4:1]), exec_en_o, VEC[i][0]);
    end

    // R10: back-to-back, Z set then EQ; then Z cleared by EQ-gated write then NE
    issue(1, 4'hE, 1, 4'b0100);
    issue(1, 4'h0, 1, 4'b0000);
    check("R10", exec_en_o, 1);
    issue(1, 4'h1, 0, 4'h0);
    check("R10", exec_en_o, 1);
    check("R10", flags_o, 4'b0000);

    // R11: failing EQ carrying a write
    issue(1, 4'h0, 1, 4'b1111);
    check("R11", exec_en_o, 0);
    issue(1, 4'hE, 0, 4'h0);
    check("R11", flags_o, 4'b0000);
    issue(1, 4'hF, 1, 4'b1010);
    check("R3", exec_en_o, 0);
    idle();
    check("R11", flags_o, 4'b0000);

    // R12: no write request; write request without valid
    issue(1, 4'hE, 0, 4'b1111);
    idle();
    check("R12", flags_o, 4'b0000);
    issue(0, 4'hE, 1, 4'b1111);
    check("R8", exec_en_o, 0);
    idle();
    check("R12", flags_o, 4'b0000);

    // R2: always code with every flag value
    for (int f = 0; f < 16; f++) begin
      issue(1, 4'hE, 1, 4'(f));
      check("R2", exec_en_o, 1);
    end
    idle();
    check("R9", flags_o, 4'hF);

    // R1: asynchronous reset clears flags
    @(negedge clk_i) rst_ni = 0;
    #1;
    check("R1", flags_o, 4'h0);
    @(negedge clk_i) rst_ni = 1;
    idle();
    check("R1", exec_en_o, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule